// File: doc/BRIEF.md
# Open-Row DRAM Command Sequencer

The block sits between a requester issuing single-word reads and writes and a DRAM command bus. Each accepted request is turned into the shortest legal command sequence for its bank. A bank whose row is still open and matches the request gets only a column command. A closed bank gets a row activate and then the column command. A bank holding a different row is precharged, then activated, then given the column command. Rows stay open after use, so a run of accesses to one row costs one column command each.

Requests are taken on a valid/ready handshake and are served strictly in arrival order, with at most one command per cycle. The minimum gaps from precharge to activate and from activate to column command are parameters, counted in clock cycles. Read data is taken from the DRAM data input a fixed number of cycles after the read command and handed back with a one-cycle valid pulse.

Top module: `dram_seq`

## Requirements
- R1: After reset every bank is closed, `req_ready_o` is 1, and `cmd_valid_o` and `rd_valid_o` are 0.
- R2: The word address is split as row = `req_addr_i[22:11]`, bank = `req_addr_i[10:9]`, column = `req_addr_i[8:0]`. `cmd_o` encodes 0 = precharge, 1 = activate, 2 = column read and 3 = column write. `cmd_bank_o` carries the request bank. `cmd_addr_o` carries the row on an activate and the zero-extended column on a column command.
- R3: A request to a closed bank issues an activate of its row and then its column command, with no precharge.
- R4: A request whose bank holds the same row open issues only the column command.
- R5: A request whose bank holds a different row issues a precharge of that bank, then an activate of the new row, then the column command.
- R6: An activate follows its precharge by exactly T_RP cycles. A column command follows its activate by exactly T_RCD cycles.
- R7: The first command of a request is issued in the cycle after the request is accepted.
- R8: `rd_valid_o` pulses for one cycle exactly T_RL+1 cycles after a column read command. `rd_data_o` then holds the value that `dram_rdata_i` had T_RL cycles after that command. Reads return in request order.
- R9: A column write presents the request write data on `cmd_wdata_o` in the cycle it is issued.
- R10: Commands appear only for accepted requests, one per cycle, in arrival order. `req_ready_o` is 0 while a precharge or activate is issued and is 1 in the cycle a column command is issued, so row hits can be accepted back to back, one per cycle.
- R11: Opening or using a row in one bank leaves the open rows of the other banks unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted at this edge when valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 23 | Word address: row, bank, column |
| req_wdata_i | input | 32 | Write data |
| cmd_valid_o | output | 1 | A command is issued this cycle |
| cmd_o | output | 2 | Command code |
| cmd_bank_o | output | 2 | Command bank |
| cmd_addr_o | output | 12 | Row or column address |
| cmd_wdata_o | output | 32 | Write data for a column write |
| dram_rdata_i | input | 32 | Read data from the DRAM |
| rd_valid_o | output | 1 | Read data valid pulse |
| rd_data_o | output | 32 | Returned read data |

## Verification
Each request's first command is due one cycle after the edge that accepted it. An activate is due T_RP cycles after its precharge and a column command T_RCD cycles after its activate. The driver records the acceptance cycle and queues every expected command with its absolute cycle number. The monitor compares kind, bank, address, write data and cycle number as each command appears. For every read command the bench DRAM model drives data in cycle c+T_RL, and the monitor expects `rd_valid_o` in cycle c+T_RL+1 with the data the request model predicts, sampling on the falling edge.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  typedef enum logic [1:0] {
    CMD_PRE = 2'd0,
    CMD_ACT = 2'd1,
    CMD_RD  = 2'd2,
    CMD_WR  = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE,
    ST_ACT,
    ST_COL
  } state_e;
endpackage

// File: rtl/dram_seq_addr.sv
module dram_seq_addr #(
  parameter int ROW_W  = 12,
  parameter int BANK_W = 2,
  parameter int COL_W  = 9,
  localparam int ADDR_W = ROW_W + BANK_W + COL_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ROW_W-1:0]  row_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [COL_W-1:0]  col_o
);
  assign col_o  = addr_i[COL_W-1:0];
  assign bank_o = addr_i[COL_W +: BANK_W];
  assign row_o  = addr_i[COL_W+BANK_W +: ROW_W];
endmodule

// File: rtl/dram_seq_rowtbl.sv
module dram_seq_rowtbl #(
  parameter int ROW_W  = 12,
  parameter int BANK_W = 2,
  localparam int NB    = 1 << BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BANK_W-1:0] lk_bank_i,
  input  logic [ROW_W-1:0]  lk_row_i,
  output logic              lk_open_o,
  output logic              lk_hit_o,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [BANK_W-1:0] up_bank_i,
  input  logic [ROW_W-1:0]  up_row_i
);
  logic [NB-1:0]            open_q;
  logic [NB-1:0][ROW_W-1:0] row_q;
  logic [NB-1:0]            hit_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= '0;
      row_q  <= '0;
    end else begin
      for (int b = 0; b < NB; b++) begin
        if (clr_i && up_bank_i == BANK_W'(b)) begin
          open_q[b] <= 1'b0;
        end else if (set_i && up_bank_i == BANK_W'(b)) begin
          open_q[b] <= 1'b1;
          row_q[b]  <= up_row_i;
        end
      end
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_cmp
    assign hit_vec[g] = open_q[g] && (row_q[g] == lk_row_i);
  end

  assign lk_open_o = open_q[lk_bank_i];
  assign lk_hit_o  = hit_vec[lk_bank_i];
endmodule

// File: rtl/dram_seq_timer.sv
module dram_seq_timer #(
  parameter int TW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/dram_seq_rdpipe.sv
module dram_seq_rdpipe #(
  parameter int DATA_W = 32,
  parameter int T_RL   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic [DATA_W-1:0] dram_rdata_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [T_RL-1:0] sr_q;

  if (T_RL == 1) begin : g_one
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sr_q <= '0;
      else         sr_q <= issue_i;
    end
  end else begin : g_shift
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sr_q <= '0;
      else         sr_q <= {sr_q[T_RL-2:0], issue_i};
    end
  end

  // capture in the cycle the DRAM drives data, present one cycle later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= sr_q[T_RL-1];
      if (sr_q[T_RL-1]) rd_data_o <= dram_rdata_i;
    end
  end
endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_seq_pkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int BANK_W = 2,
  parameter int COL_W  = 9,
  parameter int DATA_W = 32,
  parameter int T_RP   = 3,
  parameter int T_RCD  = 2,
  parameter int T_RL   = 4,
  localparam int ADDR_W = ROW_W + BANK_W + COL_W,
  localparam int CA_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              cmd_valid_o,
  output logic [1:0]        cmd_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [CA_W-1:0]   cmd_addr_o,
  output logic [DATA_W-1:0] cmd_wdata_o,
  input  logic [DATA_W-1:0] dram_rdata_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int GAP_MAX = (T_RP > T_RCD) ? T_RP : T_RCD;
  localparam int TW      = $clog2(GAP_MAX + 1);

  state_e            state_q, state_d;
  logic              q_write;
  logic [ROW_W-1:0]  q_row;
  logic [BANK_W-1:0] q_bank;
  logic [COL_W-1:0]  q_col;
  logic [DATA_W-1:0] q_wdata;

  logic [ROW_W-1:0]  in_row;
  logic [BANK_W-1:0] in_bank;
  logic [COL_W-1:0]  in_col;
  logic              lk_open, lk_hit;
  logic              gap_done;
  logic              pre_fire, act_fire, col_fire, accept;
  logic              tmr_load;
  logic [TW-1:0]     tmr_val;

  dram_seq_addr #(.ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W)) u_addr (
    .addr_i (req_addr_i),
    .row_o  (in_row),
    .bank_o (in_bank),
    .col_o  (in_col)
  );

  dram_seq_rowtbl #(.ROW_W(ROW_W), .BANK_W(BANK_W)) u_tbl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lk_bank_i (in_bank),
    .lk_row_i  (in_row),
    .lk_open_o (lk_open),
    .lk_hit_o  (lk_hit),
    .set_i     (act_fire),
    .clr_i     (pre_fire),
    .up_bank_i (q_bank),
    .up_row_i  (q_row)
  );

  dram_seq_timer #(.TW(TW)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (gap_done)
  );

  dram_seq_rdpipe #(.DATA_W(DATA_W), .T_RL(T_RL)) u_rdp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .issue_i      (col_fire && !q_write),
    .dram_rdata_i (dram_rdata_i),
    .rd_valid_o   (rd_valid_o),
    .rd_data_o    (rd_data_o)
  );

  assign pre_fire    = (state_q == ST_PRE) && gap_done;
  assign act_fire    = (state_q == ST_ACT) && gap_done;
  assign col_fire    = (state_q == ST_COL) && gap_done;
  // the column cycle frees the slot, so a hit stream runs at one per cycle
  assign req_ready_o = (state_q == ST_IDLE) || col_fire;
  assign accept      = req_valid_i && req_ready_o;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (pre_fire) begin
      tmr_load = 1'b1;
      tmr_val  = TW'(T_RP - 1);
    end else if (act_fire) begin
      tmr_load = 1'b1;
      tmr_val  = TW'(T_RCD - 1);
    end
  end

  always_comb begin
    state_d = state_q;
    if (accept) begin
      if (lk_hit)       state_d = ST_COL;
      else if (lk_open) state_d = ST_PRE;
      else              state_d = ST_ACT;
    end else if (col_fire) begin
      state_d = ST_IDLE;
    end else if (pre_fire) begin
      state_d = ST_ACT;
    end else if (act_fire) begin
      state_d = ST_COL;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      q_write <= 1'b0;
      q_row   <= '0;
      q_bank  <= '0;
      q_col   <= '0;
      q_wdata <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        q_write <= req_write_i;
        q_row   <= in_row;
        q_bank  <= in_bank;
        q_col   <= in_col;
        q_wdata <= req_wdata_i;
      end
    end
  end

  always_comb begin
    cmd_o      = CMD_PRE;
    cmd_addr_o = CA_W'(q_col);
    if (act_fire) begin
      cmd_o      = CMD_ACT;
      cmd_addr_o = CA_W'(q_row);
    end else if (col_fire) begin
      cmd_o = q_write ? CMD_WR : CMD_RD;
    end
  end

  assign cmd_valid_o = pre_fire || act_fire || col_fire;
  assign cmd_bank_o  = q_bank;
  assign cmd_wdata_o = q_wdata;
endmodule

// File: rtl/dram_seq_chk.sv
module dram_seq_chk
  import dram_seq_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int T_RP   = 3,
  parameter int T_RCD  = 2,
  localparam int NB    = 1 << BANK_W,
  localparam int CW    = $clog2(T_RP + T_RCD + 2) + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              cmd_valid_o,
  input logic [1:0]        cmd_o,
  input logic [BANK_W-1:0] cmd_bank_o
);
  logic [NB-1:0] open_q;
  logic [CW-1:0] since_pre, since_act;
  logic          is_pre, is_act, is_col;

  assign is_pre = cmd_valid_o && (cmd_o == CMD_PRE);
  assign is_act = cmd_valid_o && (cmd_o == CMD_ACT);
  assign is_col = cmd_valid_o && ((cmd_o == CMD_RD) || (cmd_o == CMD_WR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q    <= '0;
      since_pre <= '1;
      since_act <= '1;
    end else begin
      if (is_pre) open_q[cmd_bank_o] <= 1'b0;
      if (is_act) open_q[cmd_bank_o] <= 1'b1;
      if (is_pre)                 since_pre <= CW'(1);
      else if (since_pre != '1)   since_pre <= since_pre + 1'b1;
      if (is_act)                 since_act <= CW'(1);
      else if (since_act != '1)   since_act <= since_act + 1'b1;
    end
  end

  AST_ACT_ON_CLOSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_act |-> !open_q[cmd_bank_o]); // R5
  AST_PRE_ON_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_pre |-> open_q[cmd_bank_o]); // R5
  AST_COL_ON_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_col |-> open_q[cmd_bank_o]); // R3
  AST_RP_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_act |-> (since_pre >= CW'(T_RP))); // R6
  AST_RCD_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_col |-> (since_act >= CW'(T_RCD))); // R6
  AST_FIRST_CMD_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> cmd_valid_o); // R7
endmodule

bind dram_seq dram_seq_chk #(
  .BANK_W (BANK_W),
  .T_RP   (T_RP),
  .T_RCD  (T_RCD)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .cmd_valid_o (cmd_valid_o),
  .cmd_o       (cmd_o),
  .cmd_bank_o  (cmd_bank_o)
);

// File: tb/dram_seq_bench.sv
module dram_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int T_RP  = 3;
  localparam int T_RCD = 2;
  localparam int T_RL  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [22:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        cmd_valid;
  logic [1:0]  cmd;
  logic [1:0]  cmd_bank;
  logic [11:0] cmd_addr;
  logic [31:0] cmd_wdata;
  logic [31:0] dram_rdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;

  dram_seq #(.T_RP(T_RP), .T_RCD(T_RCD), .T_RL(T_RL)) u_dram_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .cmd_valid_o(cmd_valid), .cmd_o(cmd), .cmd_bank_o(cmd_bank),
    .cmd_addr_o(cmd_addr), .cmd_wdata_o(cmd_wdata),
    .dram_rdata_i(dram_rdata), .rd_valid_o(rd_valid), .rd_data_o(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  bank;
    logic [11:0] a;
    logic [31:0] wd;
    logic        first;
    int          t;
  } ecmd_t;

  ecmd_t       cq[$];
  string       tq[$];
  logic [31:0] erd_q[$];
  int          rtime_q[$];

  // request-side model
  bit          mopen[4];
  logic [11:0] mrow[4];
  logic [31:0] mmem[int];
  // DRAM-side model
  logic [11:0] drow[4];
  logic [31:0] dmem[int];
  logic [31:0] sched[int];

  function automatic logic [31:0] dflt(logic [22:0] a);
    return 32'hA500_0000 | 32'(a);
  endfunction

  function automatic logic [22:0] mk(logic [11:0] r, logic [1:0] b, logic [8:0] c);
    return {r, b, c};
  endfunction

  task automatic push(logic [1:0] op, logic [1:0] b, logic [11:0] a, logic [31:0] wd,
                      bit first, int t, string tag);
    ecmd_t e;
    e.op = op; e.bank = b; e.a = a; e.wd = wd; e.first = first; e.t = t;
    cq.push_back(e);
    tq.push_back(tag);
  endtask

  task automatic send(bit wr, logic [22:0] addr, logic [31:0] wd, string tag);
    int acc, t;
    logic [11:0] r;
    logic [1:0]  b;
    logic [8:0]  c;
    bit first;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    acc = cyc;
    r = addr[22:11]; b = addr[10:9]; c = addr[8:0];
    t = acc + 1;
    first = 1'b1;
    if (!(mopen[b] && mrow[b] == r)) begin
      if (mopen[b]) begin
        push(2'd0, b, 12'(c), wd, 1'b1, t, tag);
        t += T_RP;
        first = 1'b0;
      end
      push(2'd1, b, r, wd, first, t, tag);
      t += T_RCD;
      first = 1'b0;
      mopen[b] = 1'b1;
      mrow[b] = r;
    end
    push(wr ? 2'd3 : 2'd2, b, 12'(c), wd, first, t, tag);
    if (wr) mmem[int'(addr)] = wd;
    else erd_q.push_back(mmem.exists(int'(addr)) ? mmem[int'(addr)] : dflt(addr));
  endtask

  task automatic pause(int n);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor: commands, DRAM model, read returns
  always @(negedge clk) begin
    if (mon_on) begin
      if (cmd_valid) begin
        if (cq.size() == 0) begin
          check(1'b0, "R10", "unexpected command", longint'(cmd), 0);
        end else begin
          ecmd_t e;
          string tag;
          e = cq.pop_front();
          tag = tq.pop_front();
          check(cmd == e.op, tag, "command kind", cmd, e.op);
          check(cmd_bank == e.bank, "R2", "command bank", cmd_bank, e.bank);
          check(cmd_addr == e.a, "R2", "command address", cmd_addr, e.a);
          check(cyc == e.t, e.first ? "R7" : "R6", "command cycle", cyc, e.t);
          if (e.op == 2'd3) check(cmd_wdata == e.wd, "R9", "write data", cmd_wdata, e.wd);
          if (e.op[1]) check(req_ready == 1'b1, "R10", "ready in column cycle", req_ready, 1);
          else         check(req_ready == 1'b0, "R10", "ready in row cycle", req_ready, 0);
        end
        if (cmd == 2'd1) drow[cmd_bank] = cmd_addr;
        if (cmd == 2'd3) dmem[int'(mk(drow[cmd_bank], cmd_bank, cmd_addr[8:0]))] = cmd_wdata;
        if (cmd == 2'd2) begin
          int k;
          k = int'(mk(drow[cmd_bank], cmd_bank, cmd_addr[8:0]));
          sched[cyc + T_RL] = dmem.exists(k) ? dmem[k] : dflt(23'(k));
          rtime_q.push_back(cyc + T_RL + 1);
        end
      end
      if (rd_valid) begin
        if (rtime_q.size() == 0 || erd_q.size() == 0) begin
          check(1'b0, "R8", "unexpected read valid", 1, 0);
        end else begin
          int et;
          logic [31:0] ed;
          et = rtime_q.pop_front();
          ed = erd_q.pop_front();
          check(cyc == et, "R8", "read valid cycle", cyc, et);
          check(rd_data == ed, "R8", "read data", rd_data, ed);
        end
      end
      if (sched.exists(cyc)) begin
        dram_rdata = sched[cyc];
        sched.delete(cyc);
      end else begin
        dram_rdata = 32'hDEAD_BEEF;
      end
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      mopen[i] = 1'b0;
      mrow[i] = '0;
      drow[i] = '0;
    end
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    check(cmd_valid == 1'b0, "R1", "no command after reset", cmd_valid, 0);
    check(rd_valid == 1'b0, "R1", "no read valid after reset", rd_valid, 0);
    mon_on = 1'b1;

    send(1'b1, mk(12'd5, 2'd0, 9'd3), 32'h1111_0001, "R3");  // closed bank, no precharge
    send(1'b0, mk(12'd5, 2'd0, 9'd3), 32'h0, "R4");          // hit
    send(1'b1, mk(12'd7, 2'd1, 9'd10), 32'h2222_000A, "R3");
    send(1'b0, mk(12'd5, 2'd0, 9'd3), 32'h0, "R11");         // bank0 row kept while bank1 opened
    send(1'b0, mk(12'd9, 2'd0, 9'd3), 32'h0, "R5");          // miss
    send(1'b0, mk(12'd5, 2'd0, 9'd3), 32'h0, "R5");          // miss back, data kept
    pause(2);
    // back-to-back hits on one row
    send(1'b0, mk(12'd7, 2'd1, 9'd10), 32'h0, "R4");
    send(1'b1, mk(12'd7, 2'd1, 9'd11), 32'h3333_000B, "R4");
    send(1'b0, mk(12'd7, 2'd1, 9'd11), 32'h0, "R4");
    send(1'b0, mk(12'd7, 2'd1, 9'd12), 32'h0, "R4");
    // field boundaries
    send(1'b1, mk(12'hFFF, 2'd3, 9'h1FF), 32'h4444_FFFF, "R2");
    send(1'b0, mk(12'hFFF, 2'd3, 9'h1FF), 32'h0, "R2");
    send(1'b0, mk(12'd0, 2'd2, 9'd0), 32'h0, "R3");
    send(1'b0, mk(12'd7, 2'd1, 9'd10), 32'h0, "R11");
    send(1'b1, mk(12'd1, 2'd3, 9'd0), 32'h5555_0000, "R5");
    send(1'b0, mk(12'hFFF, 2'd3, 9'h1FF), 32'h0, "R5");
    pause(30);
    check(cq.size() == 0, "R10", "commands outstanding", cq.size(), 0);
    check(erd_q.size() == 0, "R8", "reads outstanding", erd_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule